// File: doc/BRIEF.md
# Shape-Selectable Single-Port Synchronous RAM

This block is a one-port synchronous memory. It holds 8192 bits, or 9216 bits when the word is 9, 18 or 36 bits wide. Parameters choose its depth and word width from a fixed list of shapes. Address, write data, write enable and read enable are all taken on the rising clock edge. The read data comes out of a register.

The output changes only at an edge where read enable is high. Otherwise it keeps the last value it read, even when a write takes place. When a read and a write target the same cycle, a parameter decides what the output shows: the word being written, or the word that was stored before. An optional second register delays the output by one more cycle and keeps the same hold behaviour. The memory array has no functional reset, so software must write a location before it reads it.

Top module: `spram_cfg`

## Requirements
- R1: When `ren_i` and `wen_i` are both high at an edge, `rdata_o` shows `wdata_i` if `RDW` is `RDW_NEW`. It shows the word stored at `addr_i` before that edge if `RDW` is `RDW_OLD`.
- R2: At an edge where `ren_i` is low, the read register keeps its value, including when `wen_i` is high. The output therefore stays at the last word read.
- R3: Only these shapes elaborate: DEPTH×WIDTH of 8192×1, 4096×2, 2048×4, 1024×8, 1024×9, 512×16, 512×18, 256×32 and 256×36. Any other pair stops elaboration with an error.
- R4: With `OUT_REG`=0, an edge with `ren_i` high and `wen_i` low puts the word stored at `addr_i` on `rdata_o` just after that edge.
- R5: With `OUT_REG`=1, `rdata_o` carries the same sequence of values one clock later. The extra register loads only in the cycle after an active read.
- R6: An edge with `wen_i` high stores `wdata_i` at `addr_i`. A later read of that address returns it, whatever `ren_i` was during the write.
- R7: The address width is $clog2(DEPTH). While reset is held, and after it is released, `rdata_o` is zero until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every input is sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset for the output registers; its release is synchronised inside the block |
| addr_i | input | $clog2(DEPTH) | Word address |
| wdata_i | input | WIDTH | Word to be written |
| wen_i | input | 1 | Write enable |
| ren_i | input | 1 | Read enable; when low, the output holds |
| rdata_o | output | WIDTH | Read data |

## Verification
The bench runs four shapes, covering both read-during-write modes and both output-register settings. It drives addresses at both ends of the range and repeats hits on a few addresses, so that reads and writes collide.

Each corner case catches a specific mistake:
- A design that swapped the new-data and old-data choice would show the wrong word at every collision.
- A design whose output followed the array while read enable was low would show written data during a write it should have ignored.
- A design whose extra register loaded every cycle would pass values through at the wrong time.
- A design with a wrong delay would put every compared word one cycle early or late.

// File: rtl/spram_pkg.sv
package spram_pkg;

  typedef enum logic {
    RDW_OLD = 1'b0,
    RDW_NEW = 1'b1
  } rdw_mode_e;

  function automatic bit shape_ok(input int depth, input int width);
    return (depth == 8192 && width == 1)  ||
           (depth == 4096 && width == 2)  ||
           (depth == 2048 && width == 4)  ||
           (depth == 1024 && (width == 8  || width == 9))  ||
           (depth == 512  && (width == 16 || width == 18)) ||
           (depth == 256  && (width == 32 || width == 36));
  endfunction

endpackage

// File: rtl/spram_rst_sync.sv
module spram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/spram_array.sv
module spram_array #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wen_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] stored_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wen_i) mem_q[addr_i] <= wdata_i;
  end

  assign stored_o = mem_q[addr_i];
endmodule

// File: rtl/spram_rd_stage.sv
module spram_rd_stage #(
  parameter int                    WIDTH = 8,
  parameter spram_pkg::rdw_mode_e  RDW   = spram_pkg::RDW_NEW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ren_i,
  input  logic             wen_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] q_o,
  output logic             rd_seen_o
);
  logic [WIDTH-1:0] q_d, q_q;
  logic [WIDTH-1:0] pick;
  logic             seen_q;

  generate
    if (RDW == spram_pkg::RDW_NEW) begin : g_new
      assign pick = wen_i ? wdata_i : stored_i;
    end else begin : g_old
      assign pick = stored_i;
    end
  endgenerate

  always_comb begin
    q_d = q_q;
    if (ren_i) q_d = pick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      seen_q <= 1'b0;
    end else begin
      q_q    <= q_d;
      seen_q <= ren_i;
    end
  end

  assign q_o       = q_q;
  assign rd_seen_o = seen_q;
endmodule

// File: rtl/spram_out_pipe.sv
module spram_out_pipe #(
  parameter int WIDTH  = 8,
  parameter bit ENABLE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (ENABLE) begin : g_reg
      logic [WIDTH-1:0] r_d, r_q;
      always_comb begin
        r_d = r_q;
        if (load_i) r_d = d_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
      end
      assign q_o = r_q;
    end else begin : g_pass
      logic unused_load;
      assign unused_load = load_i;
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/spram_cfg.sv
module spram_cfg #(
  parameter int                   DEPTH   = 1024,
  parameter int                   WIDTH   = 8,
  parameter spram_pkg::rdw_mode_e RDW     = spram_pkg::RDW_NEW,
  parameter bit                   OUT_REG = 1'b0,
  localparam int                  AW      = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             wen_i,
  input  logic             ren_i,
  output logic [WIDTH-1:0] rdata_o
);
  // R3: reject shapes outside the supported list
  generate
    if (!spram_pkg::shape_ok(DEPTH, WIDTH)) begin : g_bad_shape
      $error("spram_cfg: unsupported DEPTH x WIDTH");
    end
  endgenerate

  logic             rst_sync_n;
  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] stage_q;
  logic             rd_seen;

  spram_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  spram_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
    .clk_i    (clk_i),
    .wen_i    (wen_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .stored_o (stored)
  );

  spram_rd_stage #(.WIDTH(WIDTH), .RDW(RDW)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .ren_i     (ren_i),
    .wen_i     (wen_i),
    .wdata_i   (wdata_i),
    .stored_i  (stored),
    .q_o       (stage_q),
    .rd_seen_o (rd_seen)
  );

  spram_out_pipe #(.WIDTH(WIDTH), .ENABLE(OUT_REG)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .load_i (rd_seen),
    .d_i    (stage_q),
    .q_o    (rdata_o)
  );
endmodule

// File: rtl/spram_cfg_chk.sv
module spram_cfg_chk #(
  parameter int                   WIDTH   = 8,
  parameter spram_pkg::rdw_mode_e RDW     = spram_pkg::RDW_NEW,
  parameter bit                   OUT_REG = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ren_i,
  input logic             wen_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] stored_i,
  input logic [WIDTH-1:0] stage_q_i,
  input logic             rd_seen_i,
  input logic [WIDTH-1:0] rdata_i
);
  localparam bit IS_NEW = (RDW == spram_pkg::RDW_NEW);

  a_r1_rdw_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_NEW && ren_i && wen_i) |=> (stage_q_i == $past(wdata_i)));

  a_r1_rdw_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!IS_NEW && ren_i && wen_i) |=> (stage_q_i == $past(stored_i)));

  a_r4_plain_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_i && !wen_i) |=> (stage_q_i == $past(stored_i)));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_i |=> $stable(stage_q_i));

  a_r5_pipe_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_REG && rd_seen_i) |=> (rdata_i == $past(stage_q_i)));

  a_r5_pipe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_REG && !rd_seen_i) |=> $stable(rdata_i));
endmodule

bind spram_cfg spram_cfg_chk #(.WIDTH(WIDTH), .RDW(RDW), .OUT_REG(OUT_REG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_sync_n),
  .ren_i     (ren_i),
  .wen_i     (wen_i),
  .wdata_i   (wdata_i),
  .stored_i  (stored),
  .stage_q_i (stage_q),
  .rd_seen_i (rd_seen),
  .rdata_i   (rdata_o)
);

// File: tb/spram_cfg_tb_unit.sv
module spram_cfg_tb_unit #(
  parameter int                   DEPTH   = 1024,
  parameter int                   WIDTH   = 8,
  parameter spram_pkg::rdw_mode_e RDW     = spram_pkg::RDW_NEW,
  parameter bit                   OUT_REG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   errs,
  output logic done
);
  localparam int AW = $clog2(DEPTH);

  typedef struct {
    logic [WIDTH-1:0] val;
    string            tag;
  } exp_t;

  logic [AW-1:0]    addr;
  logic [WIDTH-1:0] wdata;
  logic             wen, ren;
  logic [WIDTH-1:0] rdata;

  spram_cfg #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RDW(RDW), .OUT_REG(OUT_REG)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .wdata_i (wdata),
    .wen_i   (wen),
    .ren_i   (ren),
    .rdata_o (rdata)
  );

  // reference model
  logic [WIDTH-1:0] m [DEPTH];
  logic [WIDTH-1:0] o1, o2;
  logic             prev_re;
  exp_t             sbq[$];

  function automatic logic [WIDTH-1:0] rnd();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[WIDTH-1:0];
  endfunction

  task automatic step(input logic we, input logic re, input int a,
                      input logic [WIDTH-1:0] d, input string tag);
    logic [WIDTH-1:0] n1;
    logic [AW-1:0]    aa;
    aa = a[AW-1:0];
    @(negedge clk);
    wen = we; ren = re; addr = aa; wdata = d;
    @(posedge clk);
    n1 = o1;
    if (re) n1 = (we && RDW == spram_pkg::RDW_NEW) ? d : m[aa];
    if (prev_re) o2 = o1;
    prev_re = re;
    o1 = n1;
    if (we) m[aa] = d;
    sbq.push_back('{OUT_REG ? o2 : o1, tag});
  endtask

  // monitor: pops one expected value per cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        checks++;
        if (rdata !== e.val) begin
          errs++;
          $display("FAIL %s D%0d W%0d: rdata=%h expected=%h", e.tag, DEPTH, WIDTH, rdata, e.val);
        end
      end
    end
  end

  initial begin
    string rtag;
    logic [WIDTH-1:0] v;
    checks = 0; errs = 0; done = 1'b0;
    wen = 1'b0; ren = 1'b0; addr = '0; wdata = '0;
    o1 = '0; o2 = '0; prev_re = 1'b0;
    rtag = OUT_REG ? "R5" : "R4";
    @(posedge rst_n);
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;  // R7: output is zero after reset
    if (rdata !== '0) begin
      errs++;
      $display("FAIL R7 D%0d W%0d: rdata=%h expected=0", DEPTH, WIDTH, rdata);
    end
    // R6/R2: fill every word with read enable low; output must stay zero
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, i, rnd(), "R2");
    // R4/R5: reads at both ends and the middle (R3 shape in use)
    step(1'b0, 1'b1, 0, '0, rtag);
    step(1'b0, 1'b1, DEPTH-1, '0, rtag);
    step(1'b0, 1'b1, DEPTH/2, '0, "R3");
    // R1: collision then read-back
    v = rnd();
    step(1'b1, 1'b1, 5, v, "R1");
    step(1'b0, 1'b1, 5, '0, "R6");
    step(1'b1, 1'b1, DEPTH-1, ~v, "R1");
    step(1'b1, 1'b1, DEPTH-1, v, "R1");
    // R2: write with read enable low must not disturb output
    step(1'b0, 1'b1, 9, '0, rtag);
    step(1'b1, 1'b0, 9, ~m[9], "R2");
    step(1'b0, 1'b0, 9, '0, "R2");
    step(1'b0, 1'b0, 3, '0, "R2");
    step(1'b0, 1'b1, 9, '0, "R6");
    // random mix with frequent address collisions
    for (int i = 0; i < 1200; i++) begin
      int a;
      a = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 7) : $urandom_range(0, DEPTH-1);
      step($urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0, a, rnd(), "R6");
    end
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, '0, "R2");
    wait (sbq.size() == 0);
    @(negedge clk);
    done = 1'b1;
  end
endmodule

// File: tb/spram_cfg_tb_top.sv
`timescale 1ns/1ps
module spram_cfg_tb_top;
  logic clk;
  logic rst_n;
  int   c0, c1, c2, c3, e0, e1, e2, e3;
  logic d0, d1, d2, d3;
  int   cycles;
  bit   timeout;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  spram_cfg_tb_unit #(.DEPTH(1024), .WIDTH(8),  .RDW(spram_pkg::RDW_NEW), .OUT_REG(1'b0))
    u0 (.clk(clk), .rst_n(rst_n), .checks(c0), .errs(e0), .done(d0));
  spram_cfg_tb_unit #(.DEPTH(256),  .WIDTH(36), .RDW(spram_pkg::RDW_OLD), .OUT_REG(1'b1))
    u1 (.clk(clk), .rst_n(rst_n), .checks(c1), .errs(e1), .done(d1));
  spram_cfg_tb_unit #(.DEPTH(8192), .WIDTH(1),  .RDW(spram_pkg::RDW_OLD), .OUT_REG(1'b0))
    u2 (.clk(clk), .rst_n(rst_n), .checks(c2), .errs(e2), .done(d2));
  spram_cfg_tb_unit #(.DEPTH(512),  .WIDTH(18), .RDW(spram_pkg::RDW_NEW), .OUT_REG(1'b1))
    u3 (.clk(clk), .rst_n(rst_n), .checks(c3), .errs(e3), .done(d3));

  initial begin
    timeout = 1'b0;
    cycles  = 0;
    while (!(d0 && d1 && d2 && d3)) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        timeout = 1'b1;
        break;
      end
    end
  end

  initial begin
    int tc, te;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait ((d0 && d1 && d2 && d3) || timeout);
    tc = c0 + c1 + c2 + c3;
    te = e0 + e1 + e2 + e3;
    if (timeout) begin
      tc++;
      te++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", tc, te);
    $finish;
  end
endmodule